// File: doc/BRIEF.md
# Bit-Serial Associative Order-Statistic Selector

This block keeps a small bank of integer words and selects either the largest of them or the k-th largest, treating the words as unsigned or as two's complement. It uses no comparator tree. Each cycle it inspects one bit column, starting at the most significant bit. The inspection covers every word that is still a candidate at once. A population count gives the number of candidates that hold the preferred bit value, and that number decides which candidates survive. After one step per bit, only words equal to the selected value remain active. The number of cycles depends on the word width, not on the number of words.

Software or a neighbouring block loads words through a simple write port while the selector is idle. It then pulses `start` with a mode (`sel_kth` = 0 for maximum, 1 for k-th largest), a number format (`signed_mode` = 0 unsigned, 1 two's complement) and `k_in`. When the scan finishes, the block raises `done` for a single cycle. It presents the selected value, a validity flag and the number of stored words equal to that value. These outputs hold until the next result is produced.

The controller has four named states. ST_IDLE moves to ST_SCAN on an accepted start. ST_SCAN stays in ST_SCAN while bits remain and moves to ST_PICK after bit 0. ST_PICK moves to ST_DONE unconditionally. ST_DONE returns to ST_IDLE unconditionally. Starts and writes are taken only in ST_IDLE.

Top module: `assoc_select_top`

## Requirements
- R1: After reset, `done`, `result_valid`, `result` and `resp_count` are 0, and every stored word reads as 0. A maximum search straight after reset gives 0, with `resp_count` equal to WORDS.
- R2: While the selector is idle, `wr_en` = 1 stores `wr_data` at word `wr_addr`. Later searches use the stored value.
- R3: With `sel_kth` = 0 and `signed_mode` = 0, `result` is the largest stored word as an unsigned number, and `result_valid` is 1.
- R4: With `sel_kth` = 1 and 1 <= `k_in` <= WORDS, `result` is the k-th largest stored word, with duplicates counted separately. Therefore k = 1 gives the maximum and k = WORDS gives the minimum.
- R5: With `signed_mode` = 1, words are two's complement and the most significant bit has negative weight (so 4'b1010 is -6). Both modes then order the words by signed value.
- R6: With a valid result, `resp_count` equals the number of stored words whose bit pattern equals `result`.
- R7: `done` is high for exactly one cycle. It rises after the (WIDTH+1)-th rising edge that follows the edge that samples `start`.
- R8: If `sel_kth` = 1 and `k_in` is 0 or greater than WORDS, the run still finishes with a `done` pulse, but `result_valid`, `result` and `resp_count` are all 0.
- R9: A `wr_en` or `start` raised while a run is in progress has no effect. The running result and the stored words are unchanged.
- R10: `result`, `result_valid` and `resp_count` keep their values from one result until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, honoured only while idle |
| wr_addr | input | $clog2(WORDS) | Word index to write |
| wr_data | input | WIDTH | Word value to store |
| start | input | 1 | Begin a selection, honoured only while idle |
| sel_kth | input | 1 | 0 = maximum, 1 = k-th largest |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's complement |
| k_in | input | $clog2(WORDS+1) | Rank k for k-th largest mode |
| done | output | 1 | One-cycle completion pulse |
| result_valid | output | 1 | Result is meaningful (k in range) |
| result | output | WIDTH | Selected word value |
| resp_count | output | $clog2(WORDS+1) | Number of stored words equal to the result |

## Verification
The hardest case to create from the ports is a step where the candidate set splits. Ties must survive every pruning step, and at some step the count of ones must fall just below the remaining rank, so that the rank is reduced and the zero group is kept. Random loads can reach these steps only by chance. The stimulus therefore draws many words from a narrow value range, which produces heavy duplication. It also loads directed sets with all-equal words and with mixed signs, and sweeps k from 1 to WORDS. Writes and starts are injected in the middle of a run to show that they are ignored.

// File: rtl/assoc_select_pkg.sv
package assoc_select_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_PICK = 2'd2,
        ST_DONE = 2'd3
    } sel_state_e;

endpackage

// File: rtl/assoc_word_bank.sv
module assoc_word_bank #(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [BW-1:0]    bit_idx,
    input  logic [AW-1:0]    pick_idx,
    output logic [WORDS-1:0] column,
    output logic [WIDTH-1:0] pick_word
);

    logic [WIDTH-1:0] store [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store[g] <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                store[g] <= wr_data;
            end
        end

        assign column[g] = store[g][bit_idx];
    end

    assign pick_word = store[pick_idx];

endmodule

// File: rtl/assoc_popcount.sv
module assoc_popcount #(
    parameter int N  = 8,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/assoc_lowest_pick.sv
module assoc_lowest_pick #(
    parameter int N  = 8,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [AW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = AW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/assoc_sel_ctrl.sv
module assoc_sel_ctrl
    import assoc_select_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int CW = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sel_kth,
    input  logic             signed_mode,
    input  logic [CW-1:0]    k_in,
    input  logic [WORDS-1:0] column,
    input  logic [CW-1:0]    count,
    input  logic [WIDTH-1:0] pick_word,
    input  logic             pick_any,
    output logic [WORDS-1:0] count_vec,
    output logic [WORDS-1:0] act_mask,
    output logic [BW-1:0]    bit_idx,
    output logic             in_idle,
    output logic             in_scan,
    output logic             in_pick,
    output logic             k_ok,
    output logic             done,
    output logic             result_valid,
    output logic [WIDTH-1:0] result,
    output logic [CW-1:0]    resp_count
);

    localparam logic [BW-1:0] TOP_BIT = BW'(WIDTH - 1);

    sel_state_e state_q, state_d;

    logic [WORDS-1:0] mask_q;
    logic [BW-1:0]    bit_q;
    logic [CW-1:0]    krem_q;
    logic             sgn_q;
    logic             kok_q;
    logic             search_val;
    logic [WORDS-1:0] match;
    logic             take_ones;
    logic             kin_ok;

    // search value: at the sign bit in signed mode the zero group ranks higher
    assign search_val = !(sgn_q && (bit_q == TOP_BIT));
    assign match      = (column ~^ {WORDS{search_val}}) & mask_q;
    assign take_ones  = (count >= krem_q);
    assign kin_ok     = !sel_kth || ((k_in != '0) && (k_in <= CW'(WORDS)));

    assign count_vec = (state_q == ST_PICK) ? mask_q : match;
    assign act_mask  = mask_q;
    assign bit_idx   = bit_q;
    assign in_idle   = (state_q == ST_IDLE);
    assign in_scan   = (state_q == ST_SCAN);
    assign in_pick   = (state_q == ST_PICK);
    assign k_ok      = kok_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SCAN;
            ST_SCAN: if (bit_q == '0) state_d = ST_PICK;
            ST_PICK: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // search datapath: candidate mask, bit pointer, remaining rank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            bit_q  <= TOP_BIT;
            krem_q <= '0;
            sgn_q  <= 1'b0;
            kok_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mask_q <= '1;
                        bit_q  <= TOP_BIT;
                        krem_q <= sel_kth ? k_in : CW'(1);
                        sgn_q  <= signed_mode;
                        kok_q  <= kin_ok;
                    end
                end
                ST_SCAN: begin
                    if (take_ones) begin
                        mask_q <= match;
                    end else begin
                        mask_q <= mask_q & ~match;
                        krem_q <= krem_q - count;
                    end
                    if (bit_q != '0) begin
                        bit_q <= bit_q - BW'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
            resp_count   <= '0;
        end else if (state_q == ST_PICK) begin
            result_valid <= kok_q && pick_any;
            result       <= (kok_q && pick_any) ? pick_word : '0;
            resp_count   <= (kok_q && pick_any) ? count : '0;
        end
    end

    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/assoc_select_top.sv
module assoc_select_top #(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int CW = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             start,
    input  logic             sel_kth,
    input  logic             signed_mode,
    input  logic [CW-1:0]    k_in,
    output logic             done,
    output logic             result_valid,
    output logic [WIDTH-1:0] result,
    output logic [CW-1:0]    resp_count
);

    logic [WORDS-1:0] column;
    logic [WORDS-1:0] count_vec;
    logic [WORDS-1:0] act_mask;
    logic [CW-1:0]    count;
    logic [BW-1:0]    bit_idx;
    logic [AW-1:0]    pick_idx;
    logic             pick_any;
    logic [WIDTH-1:0] pick_word;
    logic             in_idle;
    logic             in_scan;
    logic             in_pick;
    logic             k_ok;

    assoc_word_bank #(.WORDS(WORDS), .WIDTH(WIDTH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en && in_idle),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .bit_idx   (bit_idx),
        .pick_idx  (pick_idx),
        .column    (column),
        .pick_word (pick_word)
    );

    assoc_popcount #(.N(WORDS)) u_count (
        .vec   (count_vec),
        .count (count)
    );

    assoc_lowest_pick #(.N(WORDS)) u_pick (
        .vec (act_mask),
        .idx (pick_idx),
        .any (pick_any)
    );

    assoc_sel_ctrl #(.WORDS(WORDS), .WIDTH(WIDTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .sel_kth      (sel_kth),
        .signed_mode  (signed_mode),
        .k_in         (k_in),
        .column       (column),
        .count        (count),
        .pick_word    (pick_word),
        .pick_any     (pick_any),
        .count_vec    (count_vec),
        .act_mask     (act_mask),
        .bit_idx      (bit_idx),
        .in_idle      (in_idle),
        .in_scan      (in_scan),
        .in_pick      (in_pick),
        .k_ok         (k_ok),
        .done         (done),
        .result_valid (result_valid),
        .result       (result),
        .resp_count   (resp_count)
    );

endmodule

// File: rtl/assoc_select_chk.sv
module assoc_select_chk #(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int CW = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             done,
    input  logic             result_valid,
    input  logic [WIDTH-1:0] result,
    input  logic [CW-1:0]    resp_count,
    input  logic             in_idle,
    input  logic             in_scan,
    input  logic             in_pick,
    input  logic             k_ok,
    input  logic [WORDS-1:0] act_mask
);

    logic [15:0] since_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_start <= 16'hFFFF;
        end else if (in_idle && start) begin
            since_start <= 16'd0;
        end else if (since_start != 16'hFFFF) begin
            since_start <= since_start + 16'd1;
        end
    end

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_start == 16'(WIDTH + 1)));

    // R8
    invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !result_valid) |-> ((result == '0) && (resp_count == '0)));

    // R6
    tie_count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result_valid) |-> (resp_count != '0));

    // R4
    mask_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_scan && $past(in_scan)) |-> ((act_mask & ~$past(act_mask)) == '0));

    // R4
    mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_scan || in_pick) && k_ok) |-> (act_mask != '0));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_pick |=> ($stable(result) && $stable(result_valid) && $stable(resp_count)));

endmodule

bind assoc_select_top assoc_select_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .done         (done),
    .result_valid (result_valid),
    .result       (result),
    .resp_count   (resp_count),
    .in_idle      (in_idle),
    .in_scan      (in_scan),
    .in_pick      (in_pick),
    .k_ok         (k_ok),
    .act_mask     (act_mask)
);

// File: tb/assoc_select_top_bench.sv
module assoc_select_top_bench;

    localparam int WORDS = 8;
    localparam int WIDTH = 8;
    localparam int AW = 3;
    localparam int CW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             start = 1'b0;
    logic             sel_kth = 1'b0;
    logic             signed_mode = 1'b0;
    logic [CW-1:0]    k_in = '0;
    logic             done;
    logic             result_valid;
    logic [WIDTH-1:0] result;
    logic [CW-1:0]    resp_count;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [WIDTH-1:0] model [WORDS];

    always #4 clk = ~clk;

    assoc_select_top #(.WORDS(WORDS), .WIDTH(WIDTH)) u_assoc_select_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .start        (start),
        .sel_kth      (sel_kth),
        .signed_mode  (signed_mode),
        .k_in         (k_in),
        .done         (done),
        .result_valid (result_valid),
        .result       (result),
        .resp_count   (resp_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int key_of(input logic [WIDTH-1:0] w, input logic sgn);
        if (sgn) return int'($signed(w));
        return int'(w);
    endfunction

    function automatic logic [WIDTH-1:0] ref_select(input logic sgn, input int k);
        logic [WIDTH-1:0] v [WORDS];
        logic [WIDTH-1:0] t;
        for (int i = 0; i < WORDS; i++) v[i] = model[i];
        for (int i = 0; i < WORDS; i++) begin
            for (int j = 0; j < WORDS - 1 - i; j++) begin
                if (key_of(v[j], sgn) < key_of(v[j+1], sgn)) begin
                    t = v[j]; v[j] = v[j+1]; v[j+1] = t;
                end
            end
        end
        return v[k-1];
    endfunction

    function automatic int ref_ties(input logic [WIDTH-1:0] val);
        int n = 0;
        for (int i = 0; i < WORDS; i++) if (model[i] == val) n++;
        return n;
    endfunction

    task automatic write_word(input int addr, input logic [WIDTH-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        model[addr] = val;
    endtask

    task automatic run_check(input logic kth, input logic sgn, input int k, input logic inject,
                             input string tag);
        logic ok;
        logic [WIDTH-1:0] ev;
        int ec;
        int n;
        ok = !kth || (k >= 1 && k <= WORDS);
        ev = ok ? ref_select(sgn, kth ? k : 1) : '0;
        ec = ok ? ref_ties(ev) : 0;
        @(negedge clk);
        start = 1'b1; sel_kth = kth; signed_mode = sgn; k_in = CW'(k);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 64) begin
            @(negedge clk);
            n++;
            if (inject && n == 2) begin
                wr_en = 1'b1; wr_addr = '0; wr_data = ~model[0]; start = 1'b1;
            end else begin
                wr_en = 1'b0; start = 1'b0;
            end
        end
        wr_en = 1'b0; start = 1'b0;
        chk({tag, " R7 done latency"}, n, WIDTH + 1);
        chk({tag, " R8 result_valid"}, result_valid, ok);
        chk({tag, " R3 R4 R5 result"}, result, ev);
        chk({tag, " R6 resp_count"}, resp_count, ec);
        @(negedge clk);
        chk({tag, " R7 done one cycle"}, done, 0);
        chk({tag, " R10 result held"}, result, ev);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 done after reset", done, 0);
        chk("R1 valid after reset", result_valid, 0);
        chk("R1 result after reset", result, 0);
        chk("R1 count after reset", resp_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_check(1'b0, 1'b0, 0, 1'b0, "R1 reset contents");

        // R2 R3: distinct unsigned values
        write_word(0, 8'd17); write_word(1, 8'd200); write_word(2, 8'd3);
        write_word(3, 8'd128); write_word(4, 8'd99); write_word(5, 8'd255);
        write_word(6, 8'd0); write_word(7, 8'd64);
        run_check(1'b0, 1'b0, 0, 1'b0, "R2 R3 max unsigned");
        run_check(1'b0, 1'b1, 0, 1'b0, "R5 max signed");
        for (int k = 1; k <= WORDS; k++) begin
            run_check(1'b1, 1'b0, k, 1'b0, "R4 kth unsigned sweep");
            run_check(1'b1, 1'b1, k, 1'b0, "R5 kth signed sweep");
        end

        // R8: out-of-range ranks
        run_check(1'b1, 1'b0, 0, 1'b0, "R8 k zero");
        run_check(1'b1, 1'b1, WORDS + 1, 1'b0, "R8 k above count");

        // R6: all equal and heavy ties
        for (int i = 0; i < WORDS; i++) write_word(i, 8'hA5);
        run_check(1'b0, 1'b0, 0, 1'b0, "R6 all equal");
        run_check(1'b1, 1'b1, WORDS, 1'b0, "R6 all equal signed min");
        write_word(2, 8'h7F); write_word(5, 8'h80);
        run_check(1'b1, 1'b1, 2, 1'b0, "R5 R6 mixed sign ties");
        run_check(1'b1, 1'b0, 2, 1'b0, "R4 R6 unsigned ties");

        // R9: write and start during a run are ignored
        run_check(1'b0, 1'b0, 0, 1'b1, "R9 inject during run");
        run_check(1'b0, 1'b0, 0, 1'b0, "R9 memory unchanged");
        chk("R9 word0 intact via min", 32'(ref_select(1'b0, WORDS)), 32'(8'h7F));

        // constrained random with narrow ranges for ties
        for (int it = 0; it < 60; it++) begin
            for (int i = 0; i < WORDS; i++) begin
                if (it % 2 == 0) write_word(i, WIDTH'($urandom_range(0, 3)) ^ 8'h80);
                else write_word(i, WIDTH'($urandom_range(0, 255)));
            end
            run_check(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      int'($urandom_range(1, WORDS)), 1'b0, "R4 R5 R6 random");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule